// File: doc/BRIEF.md
# Time-Multiplexed Multi-Cycle FIR Filter

This block is a signed, real-valued FIR filter with a configurable tap count that spreads the work of each output over several clock cycles. The taps are split into equal groups, one group per clock. A mux-based scheduler hands each group of tap/coefficient pairs to a small bank of multipliers. The products are summed by a binary adder tree and folded into an accumulator until all groups have been processed. This trades multipliers for time: a filter with TAPS taps and CYC cycles per sample needs only ceil(TAPS/CYC) multipliers.

A sample enters on a one-clock `irdy` pulse, and that pulse starts a data cycle of CYC clocks. The finished sum lands on `dout` CYC clocks later and stays there until the next result. `ordy` flags the first clock of each output data cycle. Coefficients are written at run time, one per clock, while `coef_ld` is held high.

Top module: `fir_mc`

## Requirements
- R1: Each result equals the full-precision signed sum over i of coef[i]*tap[i], computed with ceil(TAPS/CYC) multipliers over CYC clocks; dout is OW = 2*DW + clog2(TAPS) bits wide.
- R2: On each clock edge where irdy is high, din becomes tap 0 and every tap i moves to tap i+1. On edges where irdy is low, the taps do not change.
- R3: A result appears on dout at the CYC-th rising edge after the edge that sampled irdy. ordy is high for exactly the one clock that follows that edge.
- R4: dout only changes when ordy rises, and it holds its value for the rest of the data cycle.
- R5: While coef_ld is high, each rising edge writes coef_in into coefficient slot 0, 1, 2, … in turn, wrapping after slot TAPS-1. A clock with coef_ld low restarts the next load at slot 0.
- R6: An active-low asynchronous reset, released synchronously, clears the taps, the coefficients, dout and ordy to zero.
- R7: When TAPS is not a multiple of CYC, the unused multiplier slots of the last group contribute zero to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DW | Signed input sample |
| irdy | input | 1 | Sample valid; starts a data cycle |
| coef_in | input | DW | Signed coefficient to be written |
| coef_ld | input | 1 | Sequential coefficient write enable |
| dout | output | OW | Signed filter result, held for a data cycle |
| ordy | output | 1 | High on the first clock of each output data cycle |

## Verification
The bench runs two configurations side by side: ten taps over four cycles, where the last group has two zero-padded slots, and eight taps over two cycles, where the taps divide evenly. A scheduler that routes tap indices past the end into a padded slot would give wrong sums only in the first configuration.

An impulse exposes the coefficient order. A design that shifted taps the wrong way, or shifted them without irdy, would play the coefficients back reversed or smeared. A coefficient load that is interrupted and then restarted catches a write pointer that does not return to slot 0; such a design would leave the coefficients rotated.

Gaps longer than CYC between samples catch a result that is not held, or an ordy that repeats. A reset in the middle of a computation catches taps or coefficients that survive reset.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;
  // integer division rounded up, used to size the multiplier bank
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/fir_sched.sv
// Picks the tap/coefficient group selected by sel and presents it to the
// multiplier bank. Slot j of group g carries tap index g*M+j; slots past the
// last tap are tied to zero.
module fir_sched #(
  parameter int DW   = 8,
  parameter int TAPS = 10,
  parameter int CYC  = 4,
  parameter int M    = 3,
  parameter int SELW = 2
) (
  input  logic [SELW-1:0]        sel,
  input  logic signed [DW-1:0]   taps  [TAPS],
  input  logic signed [DW-1:0]   coefs [TAPS],
  output logic signed [DW-1:0]   xs    [M],
  output logic signed [DW-1:0]   cs    [M]
);
  for (genvar j = 0; j < M; j++) begin : g_slot
    logic signed [DW-1:0] cand_x [CYC];
    logic signed [DW-1:0] cand_c [CYC];
    for (genvar g = 0; g < CYC; g++) begin : g_grp
      localparam int IDX = g * M + j;
      if (IDX < TAPS) begin : g_live
        assign cand_x[g] = taps[IDX];
        assign cand_c[g] = coefs[IDX];
      end else begin : g_pad
        assign cand_x[g] = '0;
        assign cand_c[g] = '0;
      end
    end
    assign xs[j] = cand_x[sel];
    assign cs[j] = cand_c[sel];
  end
endmodule

// File: rtl/fir_mulbank.sv
// M signed multipliers working in parallel
module fir_mulbank #(
  parameter int DW = 8,
  parameter int M  = 3,
  localparam int PW = 2 * DW
) (
  input  logic signed [DW-1:0] xs    [M],
  input  logic signed [DW-1:0] cs    [M],
  output logic signed [PW-1:0] prods [M]
);
  for (genvar j = 0; j < M; j++) begin : g_mul
    assign prods[j] = xs[j] * cs[j];
  end
endmodule

// File: rtl/fir_addtree.sv
// Binary adder tree, padded with zero leaves up to a power of two.
// Node i sums nodes 2i+1 and 2i+2; the leaves sit at P-1 .. 2P-2.
module fir_addtree #(
  parameter int N  = 3,
  parameter int IW = 16,
  parameter int OW = 20,
  localparam int P = 1 << $clog2(N)
) (
  input  logic signed [IW-1:0] ins [N],
  output logic signed [OW-1:0] sum
);
  logic signed [OW-1:0] node [2*P-1];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[P-1+i] = OW'(ins[i]);
    end else begin : g_zero
      assign node[P-1+i] = '0;
    end
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/fir_mc.sv
module fir_mc
  import fir_mc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int TAPS = 10,
  parameter int CYC  = 4,
  localparam int OW  = 2 * DW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] din,
  input  logic                 irdy,
  input  logic signed [DW-1:0] coef_in,
  input  logic                 coef_ld,
  output logic signed [OW-1:0] dout,
  output logic                 ordy
);
  localparam int M    = ceil_div(TAPS, CYC);
  localparam int SELW = $clog2(CYC);
  localparam int PTRW = $clog2(TAPS);
  localparam int PW   = 2 * DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  // state
  logic signed [DW-1:0] taps_q  [TAPS];
  logic signed [DW-1:0] taps_n  [TAPS];
  logic signed [DW-1:0] coefs_q [TAPS];
  logic signed [DW-1:0] coefs_n [TAPS];
  logic [PTRW-1:0]      cptr_q, cptr_n;
  logic [SELW-1:0]      cnt_q, cnt_n;
  logic                 busy_q, busy_n;
  logic signed [OW-1:0] acc_q, acc_n;
  logic signed [OW-1:0] dout_q, dout_n;
  logic                 ordy_q, ordy_n;

  // datapath
  logic signed [DW-1:0] xs    [M];
  logic signed [DW-1:0] cs    [M];
  logic signed [PW-1:0] prods [M];
  logic signed [OW-1:0] grp_sum;

  fir_sched #(.DW(DW), .TAPS(TAPS), .CYC(CYC), .M(M), .SELW(SELW)) u_sched (
    .sel(cnt_q), .taps(taps_q), .coefs(coefs_q), .xs(xs), .cs(cs)
  );

  fir_mulbank #(.DW(DW), .M(M)) u_mul (
    .xs(xs), .cs(cs), .prods(prods)
  );

  fir_addtree #(.N(M), .IW(PW), .OW(OW)) u_tree (
    .ins(prods), .sum(grp_sum)
  );

  // tap delay line: shift only on a sample strobe
  always_comb begin
    taps_n = taps_q;
    if (irdy) begin
      taps_n[0] = din;
      for (int i = 1; i < TAPS; i++) taps_n[i] = taps_q[i-1];
    end
  end

  // sequential coefficient write with wrapping pointer
  always_comb begin
    coefs_n = coefs_q;
    cptr_n  = '0;
    if (coef_ld) begin
      coefs_n[cptr_q] = coef_in;
      cptr_n = (cptr_q == PTRW'(TAPS - 1)) ? '0 : cptr_q + 1'b1;
    end
  end

  // group sequencing and accumulation
  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    acc_n  = acc_q;
    dout_n = dout_q;
    ordy_n = 1'b0;
    if (busy_q) begin
      acc_n = (cnt_q == '0) ? grp_sum : acc_q + grp_sum;
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == SELW'(CYC - 1)) begin
        dout_n = acc_q + grp_sum;
        ordy_n = 1'b1;
        busy_n = 1'b0;
        cnt_n  = '0;
      end
    end
    if (irdy) begin
      cnt_n  = '0;
      busy_n = 1'b1;
      acc_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < TAPS; i++) begin
        taps_q[i]  <= '0;
        coefs_q[i] <= '0;
      end
      cptr_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      acc_q  <= '0;
      dout_q <= '0;
      ordy_q <= 1'b0;
    end else begin
      taps_q  <= taps_n;
      coefs_q <= coefs_n;
      cptr_q  <= cptr_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
      acc_q   <= acc_n;
      dout_q  <= dout_n;
      ordy_q  <= ordy_n;
    end
  end

  assign dout = dout_q;
  assign ordy = ordy_q;

  AST_TAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_s)
    irdy |=> taps_q[0] == $past(din)); // R2
  AST_COEF_WRITE: assert property (@(posedge clk) disable iff (!rst_s)
    coef_ld |=> coefs_q[$past(cptr_q)] == $past(coef_in)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    !ordy |-> $stable(dout)); // R4
  AST_ORDY_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    ordy |=> !ordy); // R3
  AST_ORDY_FROM_WORK: assert property (@(posedge clk) disable iff (!rst_s)
    ordy |-> $past(busy_q)); // R3
endmodule

// File: tb/sim_fir_mc.sv
module sim_fir_mc;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic              rst_n;
  logic signed [7:0] din, coef_in;
  logic              irdy, ld_a, ld_b;
  logic signed [19:0] dout_a;
  logic signed [18:0] dout_b;
  logic              ordy_a, ordy_b;

  // u0: 10 taps over 4 cycles (padded last group), u1: 8 taps over 2 cycles
  fir_mc #(.DW(8), .TAPS(10), .CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .irdy(irdy),
    .coef_in(coef_in), .coef_ld(ld_a), .dout(dout_a), .ordy(ordy_a));
  fir_mc #(.DW(8), .TAPS(8), .CYC(2)) u1 (
    .clk(clk), .rst_n(rst_n), .din(din), .irdy(irdy),
    .coef_in(coef_in), .coef_ld(ld_b), .dout(dout_b), .ordy(ordy_b));

  int checks = 0, fails = 0;
  string phase = "R6";

  // behavioural reference model
  int     n_t [2] = '{10, 8};
  int     c_t [2] = '{4, 2};
  longint hist [2][16];
  longint cf   [2][16];
  int     ptr  [2];
  int     due  [2];
  longint yq   [2];
  longint exp_d [2];
  bit     exp_o [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < 16; i++) begin hist[k][i] = 0; cf[k][i] = 0; end
        ptr[k] = 0; due[k] = 0; yq[k] = 0; exp_d[k] = 0; exp_o[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit ldk;
        ldk = (k == 0) ? ld_a : ld_b;
        exp_o[k] = 0;
        if (due[k] > 0) begin
          due[k]--;
          if (due[k] == 0) begin exp_d[k] = yq[k]; exp_o[k] = 1; end
        end
        if (ldk) begin
          cf[k][ptr[k]] = longint'(coef_in);
          ptr[k] = (ptr[k] + 1) % n_t[k];
        end else ptr[k] = 0;
        if (irdy) begin
          for (int i = 15; i > 0; i--) hist[k][i] = hist[k][i-1];
          hist[k][0] = longint'(din);
          yq[k] = 0;
          for (int i = 0; i < n_t[k]; i++) yq[k] += cf[k][i] * hist[k][i];
          due[k] = c_t[k];
        end
      end
    end
  end

  task automatic cmp(int k, longint act_d, bit act_o);
    string t;
    checks++;
    if (act_o !== exp_o[k]) begin
      fails++;
      $display("FAIL R3 [%s] inst%0d ordy actual=%0d expected=%0d", phase, k, act_o, exp_o[k]);
    end
    checks++;
    if (act_d != exp_d[k]) begin
      t = exp_o[k] ? phase : "R4";
      if (!rst_n) t = "R6";
      fails++;
      $display("FAIL %s [%s] inst%0d dout actual=%0d expected=%0d", t, phase, k, act_d, exp_d[k]);
    end
  endtask

  always @(negedge clk) begin
    cmp(0, longint'(dout_a), ordy_a);
    cmp(1, longint'(dout_b), ordy_b);
  end

  task automatic send(input logic signed [7:0] v, input int gap);
    din = v; irdy = 1'b1;
    @(negedge clk);
    irdy = 1'b0; din = 8'($urandom_range(0, 255));
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic load(input bit which, input int n);
    for (int i = 0; i < n; i++) begin
      coef_in = 8'($urandom_range(0, 255));
      if (which) ld_b = 1'b1; else ld_a = 1'b1;
      @(negedge clk);
    end
    ld_a = 1'b0; ld_b = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(7));
    rst_n = 1'b0; din = '0; coef_in = '0; irdy = 1'b0; ld_a = 1'b0; ld_b = 1'b0;
    repeat (4) @(negedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6: coefficients cleared by reset, so every result is zero
    phase = "R6";
    for (int i = 0; i < 4; i++) send(8'($urandom_range(0, 255)), 4);
    repeat (6) @(negedge clk);

    // R5: interrupted load must restart at slot 0
    phase = "R5";
    load(1'b0, 3);
    load(1'b0, 10);
    load(1'b1, 5);
    load(1'b1, 8);
    for (int i = 0; i < 12; i++) send(8'($urandom_range(0, 255)), 4);

    // R2: impulse reads back coefficients in tap order
    phase = "R2";
    send(8'sd127, 4);
    for (int i = 0; i < 12; i++) send(8'sd0, 5);

    // R1: random samples, extremes and uneven gaps
    phase = "R1";
    send(-8'sd128, 4);
    send(-8'sd128, 4);
    send(8'sd127, 6);
    for (int i = 0; i < 30; i++) send(8'($urandom_range(0, 255)), 4 + (i % 3));

    // R7: back-to-back data cycles on the padded configuration
    phase = "R7";
    load(1'b0, 10);
    for (int i = 0; i < 20; i++) send(8'($urandom_range(0, 255)), 4);

    // R6: reset during a computation
    phase = "R6";
    send(8'sd99, 2);
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) send(8'($urandom_range(0, 255)), 4);
    repeat (10) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule